// File: doc/BRIEF.md
# Escalating Atomic Event Controller

This block follows a core's multi-line atomic events, from the first load-linked to the closing store-conditional. When an event fails it picks a stronger strategy for the retry. It starts in a speculative mode with no ordering cost. After one failure it moves to a fenced mode, which asks the pipeline for a full fence when the event opens and again when it closes. After a second failure it moves to a granted mode. In that mode every participating cache-line address is gathered into a bundle, and the bundle goes to an external arbiter just before the first store. Stores stay stalled until the arbiter grants the bundle, and a granted event cannot fail.

The controller keeps a control-point PC for the event. This is the PC of the event's first load-linked, unless a branch-on-interference instruction inside the event supplies another target. Every failure produces a one-cycle redirect carrying that PC. A context switch, a successful completion or a reset returns the controller to the speculative mode.

The states are OPT_IDLE, OPT_RUN, CAR_IDLE, CAR_RUN, MET_IDLE, MET_COLLECT, MET_WAIT and MET_OWNED. The transitions are:
- Each IDLE state goes to its RUN or COLLECT state on a load-linked.
- OPT_RUN goes to CAR_IDLE on interference and to OPT_IDLE on store-conditional.
- CAR_RUN goes to MET_IDLE on interference and to OPT_IDLE on store-conditional.
- MET_COLLECT goes to MET_IDLE on interference or bundle overflow, and to MET_WAIT on the resolving store.
- MET_WAIT goes to MET_OWNED on grant.
- MET_OWNED goes to OPT_IDLE on store-conditional.
- Any state goes to OPT_IDLE on a context switch.

Top module: `atom_event_ctrl`

## Requirements
- R1: After reset, and in the cycle after a context switch, mode_o is 0 (speculative). The encoding is 0 speculative, 1 fenced, 2 granted. A context switch raises no redirect and empties the bundle (bundle_count 0).
- R2: In the speculative mode, interference during an event gives a redirect_valid pulse exactly one cycle long in the cycle after the interference. The pulse carries the control-point PC, and mode_o becomes 1 in that same cycle.
- R3: The control point is the PC of the event's first load-linked. Later load-linked instructions in the same event leave it unchanged. A branch-on-interference inside an event replaces it with the branch target.
- R4: In the fenced mode, fence_req pulses in the cycle after the event's first load-linked. It pulses again in the cycle after a successful store-conditional, and mode_o then returns to 0.
- R5: In the fenced mode, interference during an event gives a redirect to the control point, and mode_o becomes 2.
- R6: In the granted mode, each touched line address is added to the bundle in arrival order, with slot i at bundle_lines bits [i*LINE_W +: LINE_W]. A duplicate address is not added again. bundle_count gives the number of distinct lines.
- R7: In the granted mode, the first store request sends the bundle: bundle_valid pulses for one cycle in the next cycle. stall_o is high from that cycle until the cycle after grant.
- R8: Once the arbiter has granted, interference causes no redirect, and a store-conditional returns mode_o to 0 with the bundle emptied.
- R9: A distinct line beyond BUNDLE_DEPTH (default 8) fails the event. In the next cycle overflow_err and redirect_valid pulse together, mode_o stays 2 and the bundle is emptied.
- R10: Interference outside an event has no effect. A store-conditional in the speculative mode with no interference keeps mode_o at 0 with no redirect.
- R11: When interference and store-conditional arrive in the same cycle, the event counts as failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ll_valid | input | 1 | Load-linked decoded |
| ll_pc | input | PC_W | PC of the load-linked |
| ll_line | input | LINE_W | Line address the load-linked touches |
| touch_valid | input | 1 | Another participating line touched |
| touch_line | input | LINE_W | Line address touched |
| sc_done | input | 1 | Store-conditional completed |
| interfere | input | 1 | Interference seen on the event |
| bri_valid | input | 1 | Branch-on-interference decoded |
| bri_target | input | PC_W | Branch-on-interference target |
| store_req | input | 1 | First store to a participating line |
| grant | input | 1 | Arbiter grant of the bundle |
| ctx_switch | input | 1 | Context switch into the core |
| mode_o | output | 2 | Current mode |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | PC_W | Control-point PC for the redirect |
| fence_req | output | 1 | Full fence request pulse |
| bundle_valid | output | 1 | Bundle sent to the arbiter |
| bundle_lines | output | BUNDLE_DEPTH*LINE_W | Collected line addresses |
| bundle_count | output | CNT_W | Number of valid slots |
| stall_o | output | 1 | Hold stores while waiting for grant |
| overflow_err | output | 1 | Bundle overflow pulse |

## Verification
The assertions assume the following about the inputs:
- grant arrives only while the controller is waiting for one.
- A branch-on-interference never coincides with the interference it guards.
- store_req is raised once per event, after all touches.

The stimulus keeps to these rules by driving each event as a scripted sequence of single-cycle pulses: open, touch, resolve, grant, close. Interference is injected only at the points where each requirement calls for it. The bench also places interference and context switches in idle and granted states to show that the failure paths are gated there.

// File: rtl/atom_evt_pkg.sv
package atom_evt_pkg;

    typedef enum logic [1:0] {
        MODE_OPT     = 2'd0,
        MODE_CAREFUL = 2'd1,
        MODE_METHOD  = 2'd2
    } atom_mode_e;

    typedef enum logic [2:0] {
        ST_OPT_IDLE,
        ST_OPT_RUN,
        ST_CAR_IDLE,
        ST_CAR_RUN,
        ST_MET_IDLE,
        ST_MET_COLLECT,
        ST_MET_WAIT,
        ST_MET_OWNED
    } atom_state_e;

    function automatic atom_mode_e mode_of(atom_state_e s);
        case (s)
            ST_OPT_IDLE, ST_OPT_RUN: mode_of = MODE_OPT;
            ST_CAR_IDLE, ST_CAR_RUN: mode_of = MODE_CAREFUL;
            default:                 mode_of = MODE_METHOD;
        endcase
    endfunction

    function automatic logic in_event(atom_state_e s);
        in_event = (s == ST_OPT_RUN) || (s == ST_CAR_RUN) || (s == ST_MET_COLLECT) ||
                   (s == ST_MET_WAIT) || (s == ST_MET_OWNED);
    endfunction

    function automatic logic is_idle(atom_state_e s);
        is_idle = (s == ST_OPT_IDLE) || (s == ST_CAR_IDLE) || (s == ST_MET_IDLE);
    endfunction

endpackage

// File: rtl/atom_ctrl_point.sv
module atom_ctrl_point #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [PC_W-1:0] capture_pc,
    input  logic            retarget,
    input  logic [PC_W-1:0] retarget_pc,
    output logic [PC_W-1:0] cp_o
);

    logic [PC_W-1:0] cp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_q <= '0;
        end else if (capture) begin
            cp_q <= capture_pc;
        end else if (retarget) begin
            cp_q <= retarget_pc;
        end
    end

    assign cp_o = cp_q;

    // R3: a retarget alone moves the control point to the branch label
    assert_retarget_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (retarget && !capture) |=> (cp_o == $past(retarget_pc)));

    // R3: with neither input the control point holds
    assert_cp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!retarget && !capture) |=> $stable(cp_o));

endmodule

// File: rtl/atom_line_bundle.sv
module atom_line_bundle #(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 26,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    add_valid,
    input  logic [LINE_W-1:0]       add_line,
    output logic [DEPTH*LINE_W-1:0] lines_flat,
    output logic [CNT_W-1:0]        count,
    output logic                    overflow
);

    logic [LINE_W-1:0] slot_q [DEPTH];
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  hit;
    logic              dup;
    logic              full;
    logic              accept;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign hit[g] = (CNT_W'(g) < count_q) && (slot_q[g] == add_line);
        assign lines_flat[g*LINE_W +: LINE_W] = slot_q[g];
    end

    assign dup      = |hit;
    assign full     = (count_q == CNT_W'(DEPTH));
    assign accept   = add_valid && !dup && !full;
    assign overflow = add_valid && !dup && full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (accept) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == count_q) slot_q[i] <= add_line;
            end
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R6: occupancy never passes the bundle depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    // R6: a merged duplicate leaves the occupancy unchanged
    assert_dup_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (add_valid && dup && !clear) |=> $stable(count_q));

endmodule

// File: rtl/atom_event_ctrl.sv
module atom_event_ctrl
    import atom_evt_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int LINE_W       = 26,
    parameter int BUNDLE_DEPTH = 8,
    localparam int CNT_W       = $clog2(BUNDLE_DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ll_valid,
    input  logic [PC_W-1:0]                ll_pc,
    input  logic [LINE_W-1:0]              ll_line,
    input  logic                           touch_valid,
    input  logic [LINE_W-1:0]              touch_line,
    input  logic                           sc_done,
    input  logic                           interfere,
    input  logic                           bri_valid,
    input  logic [PC_W-1:0]                bri_target,
    input  logic                           store_req,
    input  logic                           grant,
    input  logic                           ctx_switch,
    output logic [1:0]                     mode_o,
    output logic                           redirect_valid,
    output logic [PC_W-1:0]                redirect_pc,
    output logic                           fence_req,
    output logic                           bundle_valid,
    output logic [BUNDLE_DEPTH*LINE_W-1:0] bundle_lines,
    output logic [CNT_W-1:0]               bundle_count,
    output logic                           stall_o,
    output logic                           overflow_err
);

    atom_state_e       state_q, state_n;
    logic [PC_W-1:0]   cp_q;
    logic              cp_cap, cp_retarget;
    logic              add_v, bnd_clear, bnd_ovf;
    logic [LINE_W-1:0] add_l;
    logic              redir_n, fence_n, bvld_n, ovf_n;

    atom_ctrl_point #(.PC_W(PC_W)) cp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (cp_cap),
        .capture_pc  (ll_pc),
        .retarget    (cp_retarget),
        .retarget_pc (bri_target),
        .cp_o        (cp_q)
    );

    atom_line_bundle #(.DEPTH(BUNDLE_DEPTH), .LINE_W(LINE_W), .CNT_W(CNT_W)) bundle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (bnd_clear),
        .add_valid  (add_v),
        .add_line   (add_l),
        .lines_flat (bundle_lines),
        .count      (bundle_count),
        .overflow   (bnd_ovf)
    );

    // next-state and pulse decisions
    always_comb begin
        state_n = state_q;
        redir_n = 1'b0;
        fence_n = 1'b0;
        bvld_n  = 1'b0;
        ovf_n   = 1'b0;
        cp_cap  = 1'b0;
        add_v   = 1'b0;
        add_l   = ll_line;
        if (ctx_switch) begin
            state_n = ST_OPT_IDLE;
        end else begin
            unique case (state_q)
                ST_OPT_IDLE: if (ll_valid) begin
                    cp_cap  = 1'b1;
                    state_n = ST_OPT_RUN;
                end
                ST_OPT_RUN: if (interfere) begin
                    redir_n = 1'b1;
                    state_n = ST_CAR_IDLE;
                end else if (sc_done) begin
                    state_n = ST_OPT_IDLE;
                end
                ST_CAR_IDLE: if (ll_valid) begin
                    cp_cap  = 1'b1;
                    fence_n = 1'b1;
                    state_n = ST_CAR_RUN;
                end
                ST_CAR_RUN: if (interfere) begin
                    redir_n = 1'b1;
                    state_n = ST_MET_IDLE;
                end else if (sc_done) begin
                    fence_n = 1'b1;
                    state_n = ST_OPT_IDLE;
                end
                ST_MET_IDLE: if (ll_valid) begin
                    cp_cap  = 1'b1;
                    add_v   = 1'b1;
                    state_n = ST_MET_COLLECT;
                end
                ST_MET_COLLECT: begin
                    if (interfere) begin
                        redir_n = 1'b1;
                        state_n = ST_MET_IDLE;
                    end else if (ll_valid || touch_valid) begin
                        add_v = 1'b1;
                        add_l = ll_valid ? ll_line : touch_line;
                        if (bnd_ovf) begin
                            ovf_n   = 1'b1;
                            redir_n = 1'b1;
                            state_n = ST_MET_IDLE;
                        end
                    end else if (store_req) begin
                        bvld_n  = 1'b1;
                        state_n = ST_MET_WAIT;
                    end
                end
                ST_MET_WAIT: if (grant) begin
                    state_n = ST_MET_OWNED;
                end
                ST_MET_OWNED: if (sc_done) begin
                    state_n = ST_OPT_IDLE;
                end
                default: state_n = ST_OPT_IDLE;
            endcase
        end
    end

    assign cp_retarget = bri_valid && in_event(state_q) && !ctx_switch;
    assign bnd_clear   = is_idle(state_n);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPT_IDLE;
        else        state_q <= state_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
            fence_req      <= 1'b0;
            bundle_valid   <= 1'b0;
            overflow_err   <= 1'b0;
        end else begin
            redirect_valid <= redir_n;
            fence_req      <= fence_n;
            bundle_valid   <= bvld_n;
            overflow_err   <= ovf_n;
            if (redir_n) redirect_pc <= cp_q;
        end
    end

    assign mode_o  = mode_of(state_q);
    assign stall_o = (state_q == ST_MET_WAIT);

    // R1: a context switch lands in the speculative mode
    assert_ctx_home_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> (mode_o == MODE_OPT) && !redirect_valid);

    // R2: redirect is a single-cycle pulse
    assert_redirect_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R4: fences are requested only outside the granted mode
    assert_fence_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |-> (mode_o != MODE_METHOD));

    // R7: the bundle goes out non-empty with stores already held
    assert_bundle_sent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_valid |-> (bundle_count != '0) && stall_o);

    // R7: stall is only raised in the granted mode
    assert_stall_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (mode_o == MODE_METHOD));

    // R8: a granted event never fails
    assert_owned_no_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MET_OWNED) |=> !redirect_valid);

    // R9: overflow fails the event and stays in the granted mode
    assert_ovf_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |-> redirect_valid && (mode_o == MODE_METHOD) && (bundle_count == '0));

endmodule

// File: tb/atom_event_ctrl_tb_top.sv
module atom_event_ctrl_tb_top;

    localparam int PW = 32;
    localparam int LW = 26;
    localparam int DP = 8;
    localparam int CW = $clog2(DP + 1);
    localparam logic [1:0] M_O = 2'd0, M_C = 2'd1, M_M = 2'd2;

    typedef struct packed {
        logic ll; logic [PW-1:0] pc; logic [LW-1:0] line;
        logic touch; logic [LW-1:0] tline;
        logic sc; logic intf; logic bri; logic [PW-1:0] bpc;
        logic st; logic gnt; logic ctx;
    } stim_t;

    typedef struct packed {
        logic [7:0] req; logic [1:0] m; logic redir; logic [PW-1:0] rpc;
        logic fence; logic stall; logic bvld; logic ovf; logic signed [7:0] cnt;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ll_valid = 0, touch_valid = 0, sc_done = 0, interfere = 0;
    logic bri_valid = 0, store_req = 0, grant = 0, ctx_switch = 0;
    logic [PW-1:0] ll_pc = '0, bri_target = '0;
    logic [LW-1:0] ll_line = '0, touch_line = '0;
    logic [1:0] mode_o;
    logic redirect_valid, fence_req, bundle_valid, stall_o, overflow_err;
    logic [PW-1:0] redirect_pc;
    logic [DP*LW-1:0] bundle_lines;
    logic [CW-1:0] bundle_count;

    int checks = 0, fails = 0, cycles = 0;
    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    atom_event_ctrl #(.PC_W(PW), .LINE_W(LW), .BUNDLE_DEPTH(DP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_pc(ll_pc), .ll_line(ll_line),
        .touch_valid(touch_valid), .touch_line(touch_line), .sc_done(sc_done),
        .interfere(interfere), .bri_valid(bri_valid), .bri_target(bri_target),
        .store_req(store_req), .grant(grant), .ctx_switch(ctx_switch),
        .mode_o(mode_o), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .fence_req(fence_req), .bundle_valid(bundle_valid), .bundle_lines(bundle_lines),
        .bundle_count(bundle_count), .stall_o(stall_o), .overflow_err(overflow_err)
    );

    function automatic stim_t nil();
        nil = '0;
    endfunction

    function automatic exp_t ex(int r, logic [1:0] m, int c);
        ex = '0; ex.req = r[7:0]; ex.m = m; ex.cnt = c[7:0];
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // driver: apply one cycle of stimulus and queue what must follow it
    task automatic cyc(input stim_t s, input exp_t x);
        @(posedge clk); #2;
        ll_valid = s.ll; ll_pc = s.pc; ll_line = s.line;
        touch_valid = s.touch; touch_line = s.tline;
        sc_done = s.sc; interfere = s.intf; bri_valid = s.bri; bri_target = s.bpc;
        store_req = s.st; grant = s.gnt; ctx_switch = s.ctx;
        q.push_back(x);
    endtask

    // monitor: score the outputs produced by the edge that sampled each item
    initial begin
        forever begin
            @(posedge clk);
            if (q.size() != 0) begin
                exp_t x;
                logic bad;
                x = q.pop_front();
                @(negedge clk);
                bad = (mode_o != x.m) || (redirect_valid != x.redir) ||
                      (x.redir && redirect_pc != x.rpc) || (fence_req != x.fence) ||
                      (stall_o != x.stall) || (bundle_valid != x.bvld) ||
                      (overflow_err != x.ovf) ||
                      (x.cnt >= 0 && bundle_count != CW'(x.cnt));
                checks++;
                if (bad) begin
                    fails++;
                    $display("FAIL R%0d: act mode=%0d redir=%0b pc=%h fence=%0b stall=%0b bvld=%0b ovf=%0b cnt=%0d | exp mode=%0d redir=%0b pc=%h fence=%0b stall=%0b bvld=%0b ovf=%0b cnt=%0d",
                        x.req, mode_o, redirect_valid, redirect_pc, fence_req, stall_o,
                        bundle_valid, overflow_err, bundle_count, x.m, x.redir, x.rpc,
                        x.fence, x.stall, x.bvld, x.ovf, x.cnt);
                end
            end
        end
    end

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                checks++; fails++;
                $display("FAIL watchdog: act cycles=%0d exp below 5000", cycles);
                summary();
            end
        end
    end

    initial begin
        stim_t s;
        exp_t x;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        cyc(nil(), ex(1, M_O, 0));
        // R10: interference with no event open
        s = nil(); s.intf = 1; cyc(s, ex(10, M_O, 0));
        // R10: clean event stays speculative
        s = nil(); s.ll = 1; s.pc = 32'h100; s.line = 26'h10; cyc(s, ex(10, M_O, 0));
        s = nil(); s.sc = 1; cyc(s, ex(10, M_O, 0));

        // R2 / R3: failure redirects to the first load-linked PC
        s = nil(); s.ll = 1; s.pc = 32'h200; cyc(s, ex(3, M_O, 0));
        s = nil(); s.ll = 1; s.pc = 32'h240; cyc(s, ex(3, M_O, 0));
        x = ex(2, M_C, 0); x.redir = 1; x.rpc = 32'h200;
        s = nil(); s.intf = 1; cyc(s, x);
        cyc(nil(), ex(2, M_C, 0));

        // R4: fenced event succeeds
        x = ex(4, M_C, 0); x.fence = 1;
        s = nil(); s.ll = 1; s.pc = 32'h300; cyc(s, x);
        x = ex(4, M_O, 0); x.fence = 1;
        s = nil(); s.sc = 1; cyc(s, x);
        cyc(nil(), ex(4, M_O, 0));

        // R5 / R3: two failures with a branch-on-interference retarget
        s = nil(); s.ll = 1; s.pc = 32'h400; cyc(s, ex(5, M_O, 0));
        x = ex(5, M_C, 0); x.redir = 1; x.rpc = 32'h400;
        s = nil(); s.intf = 1; cyc(s, x);
        x = ex(5, M_C, 0); x.fence = 1;
        s = nil(); s.ll = 1; s.pc = 32'h400; cyc(s, x);
        s = nil(); s.bri = 1; s.bpc = 32'h480; cyc(s, ex(3, M_C, 0));
        x = ex(5, M_M, 0); x.redir = 1; x.rpc = 32'h480;
        s = nil(); s.intf = 1; cyc(s, x);

        // R6: collection with a duplicate
        s = nil(); s.ll = 1; s.pc = 32'h500; s.line = 26'h21; cyc(s, ex(6, M_M, 1));
        s = nil(); s.touch = 1; s.tline = 26'h22; cyc(s, ex(6, M_M, 2));
        s = nil(); s.touch = 1; s.tline = 26'h21; cyc(s, ex(6, M_M, 2));
        s = nil(); s.touch = 1; s.tline = 26'h23; cyc(s, ex(6, M_M, 3));
        // R7: resolution sends the bundle and holds stores
        x = ex(7, M_M, 3); x.bvld = 1; x.stall = 1;
        s = nil(); s.st = 1; cyc(s, x);
        x = ex(7, M_M, 3); x.stall = 1;
        cyc(nil(), x);
        checks++;
        if (bundle_lines[0 +: LW] != 26'h21 || bundle_lines[LW +: LW] != 26'h22 ||
            bundle_lines[2*LW +: LW] != 26'h23) begin
            fails++;
            $display("FAIL R6: act slots=%h,%h,%h exp 21,22,23",
                bundle_lines[0 +: LW], bundle_lines[LW +: LW], bundle_lines[2*LW +: LW]);
        end
        // R8: grant, interference ignored, completion
        s = nil(); s.gnt = 1; cyc(s, ex(7, M_M, 3));
        s = nil(); s.intf = 1; cyc(s, ex(8, M_M, 3));
        s = nil(); s.sc = 1; cyc(s, ex(8, M_O, 0));
        cyc(nil(), ex(8, M_O, 0));

        // R9: climb back to the granted mode, then overflow the bundle
        s = nil(); s.ll = 1; s.pc = 32'h600; cyc(s, ex(9, M_O, 0));
        x = ex(9, M_C, 0); x.redir = 1; x.rpc = 32'h600;
        s = nil(); s.intf = 1; cyc(s, x);
        x = ex(9, M_C, 0); x.fence = 1;
        s = nil(); s.ll = 1; s.pc = 32'h600; cyc(s, x);
        x = ex(9, M_M, 0); x.redir = 1; x.rpc = 32'h600;
        s = nil(); s.intf = 1; cyc(s, x);
        s = nil(); s.ll = 1; s.pc = 32'h700; s.line = 26'h30; cyc(s, ex(9, M_M, 1));
        for (int i = 1; i < DP; i++) begin
            s = nil(); s.touch = 1; s.tline = 26'h30 + LW'(i); cyc(s, ex(9, M_M, i + 1));
        end
        x = ex(9, M_M, 0); x.ovf = 1; x.redir = 1; x.rpc = 32'h700;
        s = nil(); s.touch = 1; s.tline = 26'h38; cyc(s, x);
        cyc(nil(), ex(9, M_M, 0));

        // R1: context switch mid-collection
        s = nil(); s.ll = 1; s.pc = 32'h800; s.line = 26'h40; cyc(s, ex(1, M_M, 1));
        s = nil(); s.ctx = 1; cyc(s, ex(1, M_O, 0));

        // R11: interference together with store-conditional
        s = nil(); s.ll = 1; s.pc = 32'h900; cyc(s, ex(11, M_O, 0));
        x = ex(11, M_C, 0); x.redir = 1; x.rpc = 32'h900;
        s = nil(); s.intf = 1; s.sc = 1; cyc(s, x);
        s = nil(); s.ctx = 1; cyc(s, ex(1, M_O, 0));
        cyc(nil(), ex(1, M_O, 0));

        @(posedge clk); @(negedge clk); @(negedge clk);
        summary();
    end

endmodule